// File: doc/BRIEF.md
# Tick-Paced Push-Button Debouncer

This block turns the noisy contact of a mechanical push button into a clean, stable level. It also produces a single-cycle strobe each time a press is confirmed. All logic runs on one fast system clock. Time is measured in periods of a slow enable pulse, `tick_in`, which an external divider supplies at about 1 kHz. A window of 20 ms therefore needs only 20 counts, and a 6-bit counter covers it. A counter that measured the same window in raw system clocks would need about 21 bits.

The raw button first passes through a chain of synchronizer flops. A four-state machine then compares the synchronized level with the current clean level:
- `REST_LOW`: clean level 0, input agrees.
- `VERIFY_HIGH`: clean level 0, input disagrees and the window is being counted.
- `REST_HIGH`: clean level 1, input agrees.
- `VERIFY_LOW`: clean level 1, input disagrees and the window is being counted.

The transitions are:
- *disturb*: REST_LOW to VERIFY_HIGH, or REST_HIGH to VERIFY_LOW. The input starts to disagree.
- *abandon*: VERIFY_HIGH to REST_LOW, or VERIFY_LOW to REST_HIGH. The input agrees again before the window ends, and the counter clears.
- *confirm*: VERIFY_HIGH to REST_HIGH, or VERIFY_LOW to REST_LOW. The window has expired. A direct confirm from a REST state happens when a window of one tick expires on the first disagreeing tick.

Only a confirm toward REST_HIGH raises the press strobe.

Top module: `press_filter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, `clean_level` is 0 and `press_pulse` is 0.
- R2: `btn_raw` passes through `SYNC_STAGES` flops (default 2) before it is compared. A tick that is sampled on the same clock edge that first captures a new raw level is not counted toward the window.
- R3: The window counter advances only on clock edges where `tick_in` is 1. A disagreement that lasts any number of cycles without a tick leaves `clean_level` unchanged.
- R4: `clean_level` takes the synchronized level on the edge that samples the `WINDOW_TICKS`-th consecutive tick of disagreement, and not earlier. This holds in both directions. The default window is 20 ticks.
- R5: Any cycle in which the synchronized input agrees with `clean_level` clears the counter. A later disagreement needs a full new window.
- R6: `press_pulse` is 1 for exactly one cycle, on the cycle in which `clean_level` first reads 1 after being 0. A 1-to-0 change of `clean_level` produces no pulse.
- R7: The counter is `CNT_W` bits wide (default 6) and never holds a value above `WINDOW_TICKS`-1.
- R8: Ticks that arrive while the input agrees with `clean_level` change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop uses it |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle enable that paces the stability window |
| btn_raw | input | 1 | Asynchronous, bouncing button contact |
| clean_level | output | 1 | Debounced button level |
| press_pulse | output | 1 | One-cycle strobe on a confirmed press |

## Verification
The bench builds the block with `WINDOW_TICKS` = 4 and keeps the two synchronizer stages. With this short window, every tick count from zero to two past the window can be swept in both directions within a few thousand cycles. Ticks are issued one at a time, so the expected level after n ticks is simply whether n reaches the window. The expected strobe total is the number of confirmed rises. The small window also puts the interrupted-window restart, the same-edge tick and raw change, and short bounce bursts within reach.

// File: rtl/press_filter_pkg.sv
package press_filter_pkg;

    // Bit 1 of the encoding equals the clean level held in that state.
    typedef enum logic [1:0] {
        REST_LOW    = 2'b00,
        VERIFY_HIGH = 2'b01,
        REST_HIGH   = 2'b11,
        VERIFY_LOW  = 2'b10
    } filt_state_e;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= 1'b0;
                else        stg[0] <= d_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
    parameter int WINDOW = 20,
    parameter int CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    // Expiry is the tick that completes the window.
    assign expire = advance && !clear && (count_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)               count_q <= '0;
        else if (clear || expire) count_q <= '0;
        else if (advance)         count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/filter_fsm.sv
module filter_fsm
    import press_filter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_level,
    input  logic        expire,
    output filt_state_e state_q,
    output logic        clean_level,
    output logic        press_pulse
);
    filt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REST_LOW: begin
                if (sync_level) state_d = expire ? REST_HIGH : VERIFY_HIGH;
            end
            VERIFY_HIGH: begin
                if (!sync_level) state_d = REST_LOW;
                else if (expire) state_d = REST_HIGH;
            end
            REST_HIGH: begin
                if (!sync_level) state_d = expire ? REST_LOW : VERIFY_LOW;
            end
            VERIFY_LOW: begin
                if (sync_level)  state_d = REST_HIGH;
                else if (expire) state_d = REST_LOW;
            end
            default: state_d = REST_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REST_LOW;
        else        state_q <= state_d;
    end

    // Registered outputs, updated on the same edge as the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_level <= 1'b0;
            press_pulse <= 1'b0;
        end else begin
            clean_level <= (state_d == REST_HIGH) || (state_d == VERIFY_LOW);
            press_pulse <= ((state_q == REST_LOW) || (state_q == VERIFY_HIGH))
                           && (state_d == REST_HIGH);
        end
    end
endmodule

// File: rtl/press_filter.sv
module press_filter
    import press_filter_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int WINDOW_TICKS = 20,
    parameter int CNT_W        = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic btn_raw,
    output logic clean_level,
    output logic press_pulse
);
    logic             sync_level;
    logic             disagree;
    logic             expire;
    logic [CNT_W-1:0] count_q;
    filt_state_e      state_q;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (btn_raw),
        .q_out (sync_level)
    );

    assign disagree = sync_level ^ clean_level;

    settle_counter #(.WINDOW(WINDOW_TICKS), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!disagree),
        .advance (tick_in && disagree),
        .count_q (count_q),
        .expire  (expire)
    );

    filter_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_level  (sync_level),
        .expire      (expire),
        .state_q     (state_q),
        .clean_level (clean_level),
        .press_pulse (press_pulse)
    );
endmodule

// File: rtl/press_filter_chk.sv
module press_filter_chk #(
    parameter int WINDOW_TICKS = 20,
    parameter int CNT_W        = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             sync_level,
    input logic [CNT_W-1:0] count_q,
    input logic             clean_level,
    input logic             press_pulse
);
    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse);

    // R6
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> (clean_level && !$past(clean_level)));

    // R3
    change_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_level) |-> $past(tick_in));

    // R4
    full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_level) |-> ($past(count_q) == CNT_W'(WINDOW_TICKS - 1)));

    // R5
    agree_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_level == clean_level) |-> (count_q == '0));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(WINDOW_TICKS - 1));
endmodule

bind press_filter press_filter_chk #(
    .WINDOW_TICKS (WINDOW_TICKS),
    .CNT_W        (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_in     (tick_in),
    .sync_level  (sync_level),
    .count_q     (count_q),
    .clean_level (clean_level),
    .press_pulse (press_pulse)
);

// File: tb/sim_press_filter.sv
`timescale 1ns/1ps
module sim_press_filter;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_in = 1'b0;
    logic btn_raw = 1'b0;
    logic clean_level, press_pulse;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int doubles = 0;
    int exp_pulses = 0;
    logic prev_pulse = 1'b0;

    always #2.5 clk = ~clk;

    press_filter #(.SYNC_STAGES(2), .WINDOW_TICKS(W), .CNT_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .btn_raw(btn_raw),
        .clean_level(clean_level), .press_pulse(press_pulse)
    );

    // Pulse monitor, sampled between edges
    always @(negedge clk) begin
        if (rst_n && press_pulse) pulses++;
        if (rst_n && press_pulse && prev_pulse) doubles++;
        prev_pulse <= press_pulse;
    end

    task automatic chk_bit(input string req, input logic act, input logic exp);
        @(negedge clk);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_raw(input logic v);
        @(posedge clk); #1 btn_raw = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1 tick_in = 1'b1;
            @(posedge clk); #1 tick_in = 1'b0;
            @(posedge clk);
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        chk_bit("R1 clean in reset", clean_level, 1'b0);
        chk_bit("R1 pulse in reset", press_pulse, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        chk_bit("R1 clean after release", clean_level, 1'b0);

        // R8: ticks while agreeing
        tick_n(2 * W);
        chk_bit("R8 idle ticks", clean_level, 1'b0);

        // R4 rising sweep, R6 pulse count
        for (int n = 0; n <= W + 2; n++) begin
            set_raw(1'b1);
            tick_n(n);
            chk_bit("R4 rise after n ticks", clean_level, n >= W);
            if (n >= W) exp_pulses++;
            set_raw(1'b0);
            tick_n(W);
            chk_bit("R4 return low", clean_level, 1'b0);
            chk_int("R6 pulse count", pulses, exp_pulses);
        end

        // R4 falling sweep, R6 no pulse on fall
        for (int n = 0; n <= W + 2; n++) begin
            set_raw(1'b1);
            tick_n(W);
            exp_pulses++;
            set_raw(1'b0);
            tick_n(n);
            chk_bit("R4 fall after n ticks", clean_level, n < W);
            tick_n(W);
            chk_bit("R4 settled low", clean_level, 1'b0);
            chk_int("R6 no pulse on fall", pulses, exp_pulses);
        end

        // R3: long disagreement without ticks
        set_raw(1'b1);
        repeat (200) @(posedge clk);
        chk_bit("R3 no tick no change", clean_level, 1'b0);
        set_raw(1'b0);

        // R5: interrupted window restarts
        set_raw(1'b1);
        tick_n(W - 1);
        set_raw(1'b0);
        set_raw(1'b1);
        tick_n(W - 1);
        chk_bit("R5 restarted window", clean_level, 1'b0);
        tick_n(1);
        chk_bit("R5 full window", clean_level, 1'b1);
        exp_pulses++;
        chk_int("R6 pulse after restart", pulses, exp_pulses);
        set_raw(1'b0);
        tick_n(W);
        chk_bit("R5 back low", clean_level, 1'b0);

        // R2: tick on the edge that first captures the raw change
        @(posedge clk); #1 btn_raw = 1'b1; tick_in = 1'b1;
        @(posedge clk); #1 tick_in = 1'b0;
        repeat (3) @(posedge clk);
        tick_n(W - 1);
        chk_bit("R2 early tick ignored", clean_level, 1'b0);
        tick_n(1);
        chk_bit("R2 window completes", clean_level, 1'b1);
        exp_pulses++;
        set_raw(1'b0);
        tick_n(W);

        // R5/R6: bounce bursts shorter than the window
        for (int i = 0; i < 8; i++) begin
            set_raw(i % 2 == 0);
            tick_n(i % (W - 1));
        end
        set_raw(1'b0);
        chk_bit("R5 bounce filtered", clean_level, 1'b0);
        chk_int("R6 bounce pulse count", pulses, exp_pulses);
        chk_int("R6 pulse width", doubles, 0);

        finish_run();
    end
endmodule